// File: doc/BRIEF.md
# Pausable Reloading Down-Counter Timer

This block is one timer channel that counts down once for every prescaled tick. Software programs an interval and turns on the run bit. The channel then counts down from the interval to zero. On the tick that finds the counter at zero, it raises a one-clock expiry pulse, refills the counter from the interval and keeps going.

Clearing the run bit freezes the counter at its present value. Setting the run bit again on its own continues from that frozen value. To restart from a freshly written interval, software sets the reload bit and the run bit in the same write. After a stop, the channel does not resume until two ticks have passed. A start request that arrives sooner is kept and takes effect once the gap is over.

The block sits on a simple single-cycle register bus. A write takes effect at the clock edge on which it is presented. A read is combinational and returns its value in the same cycle.

Top module: `hold_timer`

## Requirements
- R1: After reset, the control register, the interval register and the current-value register all read 0, and `expire` is low.
- R2: The control register is at offset 0x10. Bit 0 is the run bit and bit 1 is the reload bit. The interval register is at offset 0x14 and is a full-width read/write register. The current-value register is at offset 0x18.
- R3: The first enabled tick after reset loads the interval into the counter and does not raise `expire`. Ticks that arrive while the run bit is 0 leave the counter at 0.
- R4: While running, the counter drops by exactly one on each cycle where `tick` is high, and it does not change on cycles where `tick` is low.
- R5: An enabled tick that finds the counter at 0 raises `expire` for the one clock after that edge and refills the counter from the interval. Counting then continues with the next tick.
- R6: While the run bit is 0, the counter holds its value through ticks and through interval rewrites. Setting only the run bit resumes the count from the held value.
- R7: Writing 1 to the reload bit sets a pending flag that reads back as 1. The next enabled tick copies the interval into the counter, and the flag then reads 0. Writing 0 to the reload bit does not cancel a pending reload.
- R8: When the run bit goes from 1 to 0, the counter stays frozen until two ticks have passed after the stop. This holds even if the run bit is set again during that window.
- R9: A read of the current-value register returns the live counter value in the same cycle, with no added latency.
- R10: Writes to the current-value register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational; 0 when idle or at an unmapped offset |
| tick | input | 1 | Prescaled tick enable, one clock wide per tick |
| expire | output | 1 | One-clock pulse when the count wraps through zero |

## Verification
The count is driven with runs of back-to-back ticks and with ticks separated by idle clocks. This tells decrement-per-tick apart from decrement-per-clock.

A pause is followed in one case by a plain resume and in another by a combined reload-and-run write. This separates resuming from the held value from restarting at the new interval.

A stop followed at once by a restart probes the two-tick hold-off, tick by tick. Ticks before the first start, and a write to the read-only counter register, show that those inputs leave the count untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int RUN_BIT = 0;
   localparam int RLD_BIT = 1;
   localparam int CTRL_BITS = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int ADDR_W   = 8,
   parameter int OFS_CTRL = 'h10,
   parameter int OFS_INTV = 'h14,
   parameter int OFS_CUR  = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic [WIDTH-1:0]  cnt,
   input  logic              took,
   output logic              run_bit,
   output logic              rld_bit,
   output logic [WIDTH-1:0]  interval
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(OFS_INTV);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CUR);

   logic wr_ctrl, wr_intv;
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_intv = wr_en && (addr == A_INTV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_bit  <= 1'b0;
         rld_bit  <= 1'b0;
         interval <= '0;
      end else begin
         if (wr_ctrl) begin
            run_bit <= wdata[RUN_BIT];
            rld_bit <= wdata[RLD_BIT] | (rld_bit & ~took);
         end else if (took) begin
            rld_bit <= 1'b0;
         end
         if (wr_intv) interval <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == A_CTRL) begin
            rdata[RUN_BIT] = run_bit;
            rdata[RLD_BIT] = rld_bit;
         end else if (addr == A_INTV) begin
            rdata = interval;
         end else if (addr == A_CUR) begin
            rdata = cnt;
         end
      end
   end

   // R7: a taken reload clears the flag unless a new reload write lands in the same cycle
   a_r7_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !(wr_ctrl && wdata[RLD_BIT])) |=> !rld_bit);

   // R10: a write to the counter offset leaves every register alone
   a_r10_cur_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CUR && !took) |=> ($stable(interval) && $stable(run_bit) && $stable(rld_bit)));
endmodule

// File: rtl/tmr_gap_guard.sv
module tmr_gap_guard #(
   parameter int GAP_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run_bit,
   output logic run
);
   generate
      if (GAP_TICKS == 0) begin : g_nogap
         assign run = run_bit;
      end else begin : g_gap
         localparam int GW = $clog2(GAP_TICKS + 1);
         logic [GW-1:0] gap;
         logic          run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap   <= '0;
               run_q <= 1'b0;
            end else begin
               run_q <= run_bit;
               if (run_q && !run_bit)
                  gap <= GW'(GAP_TICKS);
               else if (tick && gap != '0)
                  gap <= gap - 1'b1;
            end
         end

         assign run = run_bit && (gap == '0);

         // R8: right after a stop has been seen, the channel may not run
         a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && !run_bit) |=> !run);
      end
   endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             rld_bit,
   input  logic [WIDTH-1:0] interval,
   output logic [WIDTH-1:0] cnt,
   output logic             took,
   output logic             expire
);
   logic primed;
   logic step;

   assign step = tick && run;
   assign took = step && (rld_bit || !primed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         primed <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (step) begin
            if (took) begin
               cnt    <= interval;
               primed <= 1'b1;
            end else if (cnt == '0) begin
               cnt    <= interval;
               expire <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R6: without an enabled tick the count is frozen
   a_r6_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));

   // R4: an ordinary enabled tick lowers the count by one
   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !took && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R7: a reload tick copies the interval
   a_r7_take_interval: assert property (@(posedge clk) disable iff (!rst_n)
      (step && rld_bit) |=> (cnt == $past(interval)));

   // R5: expiry only follows an enabled tick
   a_r5_expire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(step));
endmodule

// File: rtl/hold_timer.sv
module hold_timer
   import tmr_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int ADDR_W    = 8,
   parameter int OFS_CTRL  = 'h10,
   parameter int OFS_INTV  = 'h14,
   parameter int OFS_CUR   = 'h18,
   parameter int GAP_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic              tick,
   output logic              expire
);
   generate
      if (WIDTH < CTRL_BITS) begin : g_bad_width
         $error("hold_timer: WIDTH too small for control bits");
      end
      if (OFS_CTRL >= (1 << ADDR_W) || OFS_INTV >= (1 << ADDR_W) || OFS_CUR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("hold_timer: register offset exceeds address width");
      end
      if (GAP_TICKS < 0) begin : g_bad_gap
         $error("hold_timer: GAP_TICKS must be non-negative");
      end
   endgenerate

   logic             run_bit, rld_bit, run, took;
   logic [WIDTH-1:0] interval, cnt;

   tmr_regs #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W),
      .OFS_CTRL(OFS_CTRL), .OFS_INTV(OFS_INTV), .OFS_CUR(OFS_CUR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .cnt(cnt), .took(took),
      .run_bit(run_bit), .rld_bit(rld_bit), .interval(interval)
   );

   tmr_gap_guard #(.GAP_TICKS(GAP_TICKS)) u_gap (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_bit(run_bit), .run(run)
   );

   tmr_count_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .rld_bit(rld_bit),
      .interval(interval), .cnt(cnt), .took(took), .expire(expire)
   );

   // R1: no expiry pulse while the channel has never been started
   a_r1_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> !expire);
endmodule

// File: tb/hold_timer_bench.sv
`timescale 1ns/1ps
module hold_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        expire;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   localparam logic [7:0] A_CTRL = 8'h10, A_INTV = 8'h14, A_CUR = 8'h18;

   always #2.5 clk = ~clk;

   hold_timer u_hold_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick(tick), .expire(expire)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      rd_en = 1'b1; addr = a;
      #1 v = rdata;
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse(output logic ex);
      tick = 1'b1;
      @(posedge clk); #1;
      ex = expire;
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      logic ex;
      for (int i = 0; i < n; i++) pulse(ex);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 expire", {31'b0, expire}, 32'h0);
      rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
      rd(A_INTV, v); chk("R1 interval", v, 32'h0);
      rd(A_CUR, v);  chk("R1 current", v, 32'h0);
   endtask

   task automatic t_start_and_count;
      logic [31:0] v; logic ex;
      wr(A_INTV, 32'd5);
      rd(A_INTV, v); chk("R2 interval readback", v, 32'd5);
      ticks(2);
      rd(A_CUR, v); chk("R3 ticks while stopped", v, 32'd0);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL, v); chk("R2 run bit", v, 32'h1);
      pulse(ex);
      chk("R3 no expire on load", {31'b0, ex}, 32'h0);
      rd(A_CUR, v); chk("R3 first tick loads", v, 32'd5);
      repeat (3) @(negedge clk);
      rd(A_CUR, v); chk("R4 idle clocks hold", v, 32'd5);
      ticks(2);
      rd(A_CUR, v); chk("R4 back-to-back ticks", v, 32'd3);
      pulse(ex); @(negedge clk); pulse(ex); @(negedge clk); @(negedge clk); pulse(ex);
      chk("R4 no expire before zero", {31'b0, ex}, 32'h0);
      rd(A_CUR, v); chk("R9 live value at zero", v, 32'd0);
      pulse(ex);
      chk("R5 expire at wrap", {31'b0, ex}, 32'h1);
      rd(A_CUR, v); chk("R5 refill", v, 32'd5);
      chk("R5 expire one clock", {31'b0, expire}, 32'h0);
      pulse(ex);
      rd(A_CUR, v); chk("R5 continues", v, 32'd4);
   endtask

   task automatic t_pause_resume;
      logic [31:0] v;
      wr(A_CTRL, 32'h0);
      wr(A_INTV, 32'd9);
      ticks(3);
      rd(A_CUR, v); chk("R6 paused holds", v, 32'd4);
      wr(A_CTRL, 32'h1);
      ticks(1);
      rd(A_CUR, v); chk("R6 resume from held", v, 32'd3);
      wr(A_CUR, 32'h1234);
      rd(A_CUR, v); chk("R10 current not writable", v, 32'd3);
      rd(A_INTV, v); chk("R10 interval untouched", v, 32'd9);
   endtask

   task automatic t_reload;
      logic [31:0] v;
      wr(A_CTRL, 32'h3);
      rd(A_CTRL, v); chk("R7 reload pending", v, 32'h3);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL, v); chk("R7 zero does not cancel", v, 32'h3);
      ticks(1);
      rd(A_CUR, v); chk("R7 interval taken", v, 32'd9);
      rd(A_CTRL, v); chk("R7 reload cleared", v, 32'h1);
   endtask

   task automatic t_gap;
      logic [31:0] v;
      wr(A_CTRL, 32'h0);
      wr(A_CTRL, 32'h1);
      ticks(1);
      rd(A_CUR, v); chk("R8 held after one tick", v, 32'd9);
      ticks(1);
      rd(A_CUR, v); chk("R8 held after two ticks", v, 32'd9);
      ticks(1);
      rd(A_CUR, v); chk("R8 runs after gap", v, 32'd8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_start_and_count;
      t_pause_resume;
      t_reload;
      t_gap;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule